// File: doc/BRIEF.md
# Posted-Write Split-Read Bus Bridge

This block joins an upstream AHB-style bus, where several masters are arbitrated, to a downstream AHB-style bus that reaches slower targets. Both data paths are 32 bits wide. Requests from upstream go into one small shared queue, and the queue keeps their order. Writes are posted: the upstream master gets OKAY in the data phase that finds a free slot. Reads are queued and then answered with a two-cycle SPLIT response, which releases the upstream bus while the target is busy.

A separate engine takes queue entries in order. For each one it requests the downstream bus, waits for a grant and performs one single transfer. When a read returns, its data and error flag go into a buffer kept for the master that issued the read. The bridge then pulses that master's bit on a split-resume vector to the upstream arbiter. When the master comes back with its read, it collects the buffered data in one data phase, and the buffer entry becomes free. If no queue slot is free, the upstream data phase is held with wait states.

Top module: `split_post_bridge`

## Requirements
- R1: After reset, up_ready_out is 1, up_resp is OKAY (2'b00), up_split is all zero, dn_req is 0 and dn_trans is IDLE (2'b00).
- R2: A write whose data phase finds a free queue slot completes in that same cycle with up_ready_out high and OKAY. The data is taken from up_wdata in that cycle, and the write later appears unchanged on the downstream bus.
- R3: When all DEPTH queue slots are occupied, a write or a new read is held with up_ready_out low and up_resp OKAY until a slot frees.
- R4: A read from a master with no outstanding read, finding a free slot, is queued and answered with SPLIT (2'b11) in two cycles: ready low, then ready high.
- R5: When a downstream read completes, exactly one bit of up_split goes high, the bit indexed by the requesting master's ID, for one cycle. That cycle is the one after the completing downstream edge.
- R6: A read from a master whose data is buffered completes in one data phase with ready high, OKAY and the buffered word. The buffer is then freed, so the master's next read is split anew.
- R7: dn_req is high exactly while the queue holds an entry. dn_trans is NONSEQ (2'b10) only in a cycle where dn_gnt is high and no data phase is in progress. Each entry is one single transfer: an address phase, then a data phase that lasts until dn_ready is high.
- R8: Downstream transfers occur in the order the upstream requests were accepted, so a read returns the value of every earlier posted write to the same address. Address, direction and write data are held while the data phase stalls.
- R9: A downstream ERROR (2'b01) on a read is kept, and the master's collecting read gets a two-cycle ERROR response (ready low, then ready high), after which the buffer is freed. An error on a posted write is dropped.
- R10: A read from a master whose split read has not yet returned gets SPLIT again and adds no downstream transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both buses |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_sel | input | 1 | Bridge selected on the upstream bus |
| up_trans | input | 2 | Upstream transfer type (IDLE 00, NONSEQ 10, SEQ 11) |
| up_write | input | 1 | Upstream direction, 1 = write |
| up_addr | input | AW | Upstream address |
| up_wdata | input | DW | Upstream write data, valid in the data phase |
| up_master | input | MW | ID of the master owning the address phase |
| up_ready_out | output | 1 | Upstream transfer done / address taken |
| up_resp | output | 2 | Upstream response (OKAY 00, ERROR 01, SPLIT 11) |
| up_rdata | output | DW | Buffered read data for the current master |
| up_split | output | NM | One-cycle resume pulse per master |
| dn_req | output | 1 | Downstream bus request |
| dn_gnt | input | 1 | Downstream bus grant |
| dn_trans | output | 2 | Downstream transfer type |
| dn_write | output | 1 | Downstream direction |
| dn_addr | output | AW | Downstream address |
| dn_wdata | output | DW | Downstream write data |
| dn_ready | input | 1 | Downstream transfer ready |
| dn_resp | input | 2 | Downstream response |
| dn_rdata | input | DW | Downstream read data |

## Verification
The bench builds the bridge with four masters and four queue slots, which are also the defaults. With these values every master can hold a split read at the same moment, and the queue can be filled by writes alone while the grant is withheld. This brings the full-queue stall, simultaneous resume pulses on different bits, and read-after-write ordering within reach. Grant and ready probabilities are varied across phases so that both back-to-back transfers and long data-phase stalls occur.

// File: rtl/split_post_bridge.sv
module split_post_bridge #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int NM    = 4,
  parameter int DEPTH = 4,
  parameter int MW    = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_sel,
  input  logic [1:0]    up_trans,
  input  logic          up_write,
  input  logic [AW-1:0] up_addr,
  input  logic [DW-1:0] up_wdata,
  input  logic [MW-1:0] up_master,
  output logic          up_ready_out,
  output logic [1:0]    up_resp,
  output logic [DW-1:0] up_rdata,
  output logic [NM-1:0] up_split,
  output logic          dn_req,
  input  logic          dn_gnt,
  output logic [1:0]    dn_trans,
  output logic          dn_write,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_ready,
  input  logic [1:0]    dn_resp,
  input  logic [DW-1:0] dn_rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
  localparam logic [PW:0]   FULLC = (PW + 1)'(DEPTH);
  localparam logic [1:0] T_IDLE = 2'b00, T_NSEQ = 2'b10, T_SEQ = 2'b11;
  localparam logic [1:0] R_OKAY = 2'b00, R_ERR = 2'b01, R_SPLIT = 2'b11;

  typedef enum logic [1:0] {U_NORM, U_SPL2, U_ERR2} ust_t;

  // request queue
  logic [DEPTH-1:0] fw_q;
  logic [AW-1:0]    fa_q [DEPTH];
  logic [DW-1:0]    fd_q [DEPTH];
  logic [MW-1:0]    fm_q [DEPTH];
  logic [PW-1:0]    wi_q, ri_q;
  logic [PW:0]      cnt_q;

  // upstream data phase
  logic          dp_v_q, dp_w_q;
  logic [AW-1:0] dp_a_q;
  logic [MW-1:0] dp_m_q;
  ust_t          ust_q, ust_d;

  // per-master split bookkeeping
  logic [NM-1:0] pend_q, done_q, berr_q, split_q;
  logic [DW-1:0] bdat_q [NM];

  logic ds_busy_q;

  wire full   = (cnt_q == FULLC);
  wire empty  = (cnt_q == '0);
  wire accept = up_sel && (up_trans == T_NSEQ || up_trans == T_SEQ) && up_ready_out;
  wire rd_dp  = (ust_q == U_NORM) && dp_v_q && !dp_w_q;
  wire hit    = rd_dp && done_q[dp_m_q];
  wire again  = rd_dp && pend_q[dp_m_q] && !done_q[dp_m_q];
  wire push_w = (ust_q == U_NORM) && dp_v_q && dp_w_q && !full;
  wire push_r = rd_dp && !pend_q[dp_m_q] && !full;
  wire push   = push_w || push_r;
  wire take   = hit;
  wire dn_go  = !ds_busy_q && !empty && dn_gnt;
  wire pop    = ds_busy_q && dn_ready;
  wire pop_rd = pop && !fw_q[ri_q];

  always_comb begin
    up_ready_out = 1'b1;
    up_resp      = R_OKAY;
    ust_d        = U_NORM;
    case (ust_q)
      U_SPL2: up_resp = R_SPLIT;
      U_ERR2: up_resp = R_ERR;
      default: begin
        if (dp_v_q) begin
          if (dp_w_q) begin
            up_ready_out = !full;
          end else if (hit) begin
            if (berr_q[dp_m_q]) begin
              up_ready_out = 1'b0;
              up_resp      = R_ERR;
              ust_d        = U_ERR2;
            end
          end else if (again || !full) begin
            up_ready_out = 1'b0;
            up_resp      = R_SPLIT;
            ust_d        = U_SPL2;
          end else begin
            up_ready_out = 1'b0;
          end
        end
      end
    endcase
  end

  assign up_rdata = bdat_q[dp_m_q];
  assign up_split = split_q;
  assign dn_req   = !empty;
  assign dn_trans = dn_go ? T_NSEQ : T_IDLE;
  assign dn_write = fw_q[ri_q];
  assign dn_addr  = fa_q[ri_q];
  assign dn_wdata = fd_q[ri_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_v_q <= 1'b0;
      dp_w_q <= 1'b0;
      dp_a_q <= '0;
      dp_m_q <= '0;
      ust_q  <= U_NORM;
    end else begin
      ust_q <= ust_d;
      if (up_ready_out) begin
        dp_v_q <= accept;
        if (accept) begin
          dp_w_q <= up_write;
          dp_a_q <= up_addr;
          dp_m_q <= up_master;
        end
      end else if (ust_d != U_NORM) begin
        dp_v_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wi_q  <= '0;
      ri_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wi_q <= (wi_q == LAST) ? '0 : wi_q + 1'b1;
      if (pop)  ri_q <= (ri_q == LAST) ? '0 : ri_q + 1'b1;
      cnt_q <= cnt_q + (PW + 1)'(push) - (PW + 1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      fw_q[wi_q] <= dp_w_q;
      fa_q[wi_q] <= dp_a_q;
      fd_q[wi_q] <= up_wdata;
      fm_q[wi_q] <= dp_m_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_busy_q <= 1'b0;
      split_q   <= '0;
    end else begin
      ds_busy_q <= ds_busy_q ? !dn_ready : (dn_go && dn_ready);
      split_q   <= '0;
      if (pop_rd) split_q[fm_q[ri_q]] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      done_q <= '0;
      berr_q <= '0;
    end else begin
      for (int i = 0; i < NM; i++) begin
        if (push_r && dp_m_q == MW'(i))    pend_q[i] <= 1'b1;
        else if (take && dp_m_q == MW'(i)) pend_q[i] <= 1'b0;
        if (pop_rd && fm_q[ri_q] == MW'(i)) begin
          done_q[i] <= 1'b1;
          berr_q[i] <= (dn_resp == R_ERR);
        end else if (take && dp_m_q == MW'(i)) begin
          done_q[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NM; i++)
      if (pop_rd && fm_q[ri_q] == MW'(i)) bdat_q[i] <= dn_rdata;
  end

  assert_split_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(up_split));
  assert_split_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_split != '0) |=> ((up_split & $past(up_split)) == '0));
  assert_split_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_resp == R_SPLIT && !up_ready_out) |=> (up_resp == R_SPLIT && up_ready_out));
  assert_err_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_resp == R_ERR && !up_ready_out) |=> (up_resp == R_ERR && up_ready_out));
  assert_dn_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_trans == T_NSEQ) |-> (dn_gnt && dn_req));
  assert_dn_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_busy_q && !dn_ready) |=> ($stable(dn_addr) && $stable(dn_write) && $stable(dn_wdata)));
endmodule

// File: tb/split_post_bridge_bench.sv
module split_post_bridge_bench;
  localparam int CLK_NS = 10;
  localparam int NM = 4;
  localparam int DEPTH = 4;
  localparam logic [1:0] OK = 2'b00, ER = 2'b01, SP = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_sel = 1'b0;
  logic [1:0] up_trans = 2'b00;
  logic up_write = 1'b0;
  logic [31:0] up_addr = '0, up_wdata = '0;
  logic [1:0] up_master = '0;
  wire up_ready_out;
  wire [1:0] up_resp;
  wire [31:0] up_rdata;
  wire [NM-1:0] up_split;
  wire dn_req;
  logic dn_gnt = 1'b0;
  wire [1:0] dn_trans;
  wire dn_write;
  wire [31:0] dn_addr, dn_wdata;
  logic dn_ready = 1'b1;
  logic [1:0] dn_resp = 2'b00;
  logic [31:0] dn_rdata = '0;

  split_post_bridge #(.DW(32), .AW(32), .NM(NM), .DEPTH(DEPTH)) u_split_post_bridge (
    .clk(clk), .rst_n(rst_n), .up_sel(up_sel), .up_trans(up_trans), .up_write(up_write),
    .up_addr(up_addr), .up_wdata(up_wdata), .up_master(up_master),
    .up_ready_out(up_ready_out), .up_resp(up_resp), .up_rdata(up_rdata), .up_split(up_split),
    .dn_req(dn_req), .dn_gnt(dn_gnt), .dn_trans(dn_trans), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ready(dn_ready), .dn_resp(dn_resp),
    .dn_rdata(dn_rdata));

  always #(CLK_NS / 2) clk = ~clk;

  int total = 0, bad = 0, m_total = 0, m_bad = 0;
  int gnt_pct = 100, rdy_pct = 100;
  bit qw [1024];
  logic [31:0] qa [1024];
  logic [31:0] qd [1024];
  int qm [1024];
  int qt = 0, qh = 0;
  int split_cnt [NM];
  int base [NM];
  bit out_rd [NM];
  logic [31:0] exp_rd [NM];
  bit exp_er [NM];
  logic [31:0] shadow [16];
  logic [31:0] dmem [16];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic mchk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
    m_total++;
    if (!ok) begin
      m_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic bit resumed(input int m);
    return split_cnt[m] > base[m];
  endfunction

  function automatic logic [31:0] raddr(input bit allow_err);
    logic [31:0] a = '0;
    a[5:2] = 4'($urandom_range(15));
    a[8]   = allow_err && ($urandom_range(11) == 0);
    return a;
  endfunction

  // downstream target model and resume monitor
  initial begin
    bit busy = 1'b0;
    bit cw = 1'b0;
    logic [31:0] ca = '0;
    int exp_m = -1;
    logic [NM-1:0] want;
    for (int i = 0; i < 16; i++) dmem[i] = '0;
    for (int i = 0; i < NM; i++) split_cnt[i] = 0;
    forever begin
      @(negedge clk);
      want = (exp_m >= 0) ? (NM'(1) << exp_m) : '0;
      if (want != '0 || up_split != '0)
        mchk(up_split == want, "R5", "resume vector", 32'(up_split), 32'(want));
      for (int i = 0; i < NM; i++) if (up_split[i]) split_cnt[i]++;
      exp_m = -1;
      if (busy) begin
        if ($urandom_range(99) < rdy_pct) begin
          dn_ready = 1'b1;
          mchk(qh < qt && qw[qh] == cw && qa[qh] == ca, "R8", "downstream order addr", ca, qa[qh]);
          dn_resp = ca[8] ? ER : OK;
          if (cw) begin
            mchk(dn_wdata == qd[qh], "R2", "posted write data", dn_wdata, qd[qh]);
            if (!ca[8]) dmem[ca[5:2]] = dn_wdata;
          end else begin
            dn_rdata = ca[8] ? 32'hbad0_0bad : dmem[ca[5:2]];
            exp_m = qm[qh];
          end
          qh++;
          busy = 1'b0;
        end else begin
          dn_ready = 1'b0;
          dn_resp  = OK;
        end
      end else begin
        dn_ready = 1'b1;
        dn_resp  = OK;
        dn_gnt   = ($urandom_range(99) < gnt_pct);
        #1;
        if (dn_trans == 2'b10) begin
          mchk(dn_req && dn_gnt, "R7", "address phase with grant", 32'(dn_gnt), 1);
          busy = 1'b1;
          cw = dn_write;
          ca = dn_addr;
        end
      end
    end
  end

  task automatic up_xfer(input bit w, input logic [31:0] a, input logic [31:0] d, input int m,
                         output logic [1:0] fin, output logic [1:0] prev,
                         output logic [31:0] rd, output int waits);
    @(negedge clk);
    up_sel = 1'b1; up_trans = 2'b10; up_write = w; up_addr = a; up_master = 2'(m);
    while (!up_ready_out) @(negedge clk);
    @(negedge clk);
    up_sel = 1'b0; up_trans = 2'b00; up_wdata = d;
    waits = 0;
    prev = OK;
    while (!up_ready_out) begin
      prev = up_resp;
      waits++;
      @(negedge clk);
    end
    fin = up_resp;
    rd = up_rdata;
  endtask

  task automatic qpush(input bit w, input logic [31:0] a, input logic [31:0] d, input int m);
    qw[qt] = w; qa[qt] = a; qd[qt] = d; qm[qt] = m;
    qt++;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input int m,
                          input bit strict, output int waits, output logic [1:0] prev);
    logic [1:0] fin;
    logic [31:0] rd;
    up_xfer(1'b1, a, d, m, fin, prev, rd, waits);
    chk(fin == OK, "R2", "write response", 32'(fin), 32'(OK));
    if (strict) chk(waits == 0, "R2", "write wait states", waits, 0);
    qpush(1'b1, a, d, m);
    if (!a[8]) shadow[a[5:2]] = d;
  endtask

  task automatic do_read_new(input logic [31:0] a, input int m, input bit strict);
    logic [1:0] fin, prev;
    logic [31:0] rd;
    int waits;
    up_xfer(1'b0, a, '0, m, fin, prev, rd, waits);
    chk(fin == SP && prev == SP, "R4", "split response", {prev, fin}, {SP, SP});
    if (strict) chk(waits == 1, "R4", "split length", waits, 1);
    qpush(1'b0, a, '0, m);
    out_rd[m] = 1'b1;
    base[m]   = split_cnt[m];
    exp_rd[m] = a[8] ? '0 : shadow[a[5:2]];
    exp_er[m] = a[8];
  endtask

  task automatic do_retry(input int m);
    logic [1:0] fin, prev;
    logic [31:0] rd;
    int waits;
    while (!resumed(m)) @(negedge clk);
    up_xfer(1'b0, '0, '0, m, fin, prev, rd, waits);
    if (exp_er[m]) begin
      chk(fin == ER && prev == ER && waits == 1, "R9", "read error response", {prev, fin}, {ER, ER});
    end else begin
      chk(fin == OK && waits == 0, "R6", "retry response", {30'(waits), fin}, 32'(OK));
      chk(rd == exp_rd[m], "R6", "retry data", rd, exp_rd[m]);
    end
    out_rd[m] = 1'b0;
  endtask

  task automatic drain();
    while (qh != qt) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total + m_total + 1, bad + m_bad + 1);
    $finish;
  end

  initial begin
    int w;
    logic [1:0] pr, fin;
    logic [31:0] rd;
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    for (int i = 0; i < NM; i++) begin out_rd[i] = 1'b0; base[i] = 0; end

    repeat (2) @(negedge clk);
    chk(up_ready_out == 1'b1 && up_resp == OK, "R1", "upstream idle at reset", {up_ready_out, up_resp}, 32'h4);
    chk(up_split == '0 && dn_req == 1'b0 && dn_trans == 2'b00, "R1", "downstream idle at reset",
        {up_split, dn_req, dn_trans}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill the queue with grant withheld, then stall a fifth write
    gnt_pct = 0;
    for (int i = 0; i < DEPTH; i++) do_write(32'(i * 4), 32'h1000 + 32'(i), 0, 1'b1, w, pr);
    @(negedge clk);
    chk(dn_req == 1'b1 && dn_trans == 2'b00, "R7", "request without grant", {dn_req, dn_trans}, 32'h4);
    fork
      do_write(32'h10, 32'h2222_0004, 0, 1'b0, w, pr);
      begin repeat (8) @(negedge clk); gnt_pct = 100; end
    join
    chk(w >= 6, "R3", "wait states while full", w, 6);
    chk(pr == OK, "R3", "response during wait", 32'(pr), 32'(OK));
    drain();

    // pending re-request, then release after collect
    gnt_pct = 0;
    do_read_new(32'h8, 1, 1'b1);
    up_xfer(1'b0, 32'h8, '0, 1, fin, pr, rd, w);
    chk(fin == SP && pr == SP && w == 1, "R10", "re-request split again", {pr, fin}, {SP, SP});
    chk(!resumed(1), "R10", "no early resume", 32'(resumed(1)), 0);
    gnt_pct = 100;
    do_retry(1);
    do_read_new(32'h8, 1, 1'b1);
    do_retry(1);
    drain();
    chk(dn_req == 1'b0, "R7", "request drops when empty", 32'(dn_req), 0);

    // read after posted write to the same address
    gnt_pct = 0;
    do_write(32'h3c, 32'hcafe_f00d, 2, 1'b1, w, pr);
    do_read_new(32'h3c, 3, 1'b1);
    gnt_pct = 100;
    do_retry(3);
    chk(exp_rd[3] == 32'hcafe_f00d, "R8", "read sees earlier write", exp_rd[3], 32'hcafe_f00d);

    // downstream error on read and on write
    do_write(32'h104, 32'h5555_aaaa, 2, 1'b1, w, pr);
    do_read_new(32'h104, 0, 1'b1);
    do_retry(0);
    do_read_new(32'h4, 0, 1'b1);
    do_retry(0);

    // all masters outstanding together
    gnt_pct = 0;
    for (int m = 0; m < NM; m++) do_read_new(32'(m * 8), m, 1'b1);
    gnt_pct = 100;
    for (int m = NM - 1; m >= 0; m--) do_retry(m);
    drain();

    // random traffic under varying grant and ready rates
    for (int ph = 0; ph < 3; ph++) begin
      gnt_pct = (ph == 0) ? 100 : (ph == 1) ? 50 : 20;
      rdy_pct = (ph == 0) ? 100 : (ph == 1) ? 60 : 30;
      for (int it = 0; it < 200; it++) begin
        int m;
        m = $urandom_range(NM - 1);
        if (out_rd[m]) begin
          if (resumed(m)) do_retry(m);
          else @(negedge clk);
        end else if ($urandom_range(99) < 55) begin
          do_write(raddr(1'b1), $urandom, m, 1'b0, w, pr);
        end else begin
          do_read_new(raddr(1'b1), m, 1'b0);
        end
      end
      for (int m = 0; m < NM; m++) if (out_rd[m]) do_retry(m);
      drain();
      chk(qh == qt, "R8", "all queued transfers seen", qh, qt);
    end

    $display("test done: total=%0d bad=%0d", total + m_total, bad + m_bad);
    $finish;
  end
endmodule